// File: doc/BRIEF.md
# Quarter-Resolution VGA Image Fetcher

This block drives a 640x480, 60 Hz VGA raster from a 25 MHz clock. It shows a 160x120 grayscale image that lives in a shared frame memory. Each stored pixel is blown up to a 4x4 tile of screen pixels. While a tile is on screen, the block fetches the next image pixel through a request/ready handshake with the memory arbiter. This gives every fetch a budget of four clocks. The block drives an 8-bit palette index, a pixel clock and active-low horizontal sync, vertical sync and blank strobes to a palette DAC.

Two palette rules are applied on the way out. The lowest palette indices (0, 1 and 2) are kept for special colours, so any image value below 3 is raised to 3. While the motion input is high, the tiles on the outer border of the image show a reserved indicator index instead of image data. The image is stored interleaved with a second buffer. A one-bit buffer select picks the even or odd addresses, and the block takes it once per frame, at the start of vertical blanking.

Top module: `qvga_fetch_scan`

## Requirements
- R1: A line is 800 clocks: 640 visible, 16 front porch, 96 sync, 48 back porch. A frame is 525 lines: 480 visible, 10 front porch, 2 sync, 33 back porch. hSyncN is low exactly during line clocks 656..751. vSyncN is low exactly during lines 490..491.
- R2: Outside the visible area blankN is 0 and palIdx is 0. Inside it blankN is 1.
- R3: All outputs show the raster position of the previous clock, one register stage behind. Screen pixel (x, y) shows the image pixel at column x/4, row y/4, so each stored pixel fills a 4x4 tile.
- R4: The block fetches image pixel (r, c) from address 2*(r*160+c)+s, where s is the frame's buffer select. It raises memReq on the clock after the first clock of the tile just before that pixel's tile. For column 0, this is the last tile of the previous line. memAddr stays stable while memReq is high.
- R5: memReq stays high until a cycle with memReady high, and falls on the next clock. memData is taken only in a cycle with memReq and memReady both high. A memReady pulse while memReq is low has no effect on the display.
- R6: A fetched value of 0, 1 or 2 is shown as palette index 3. Other values are shown unchanged.
- R7: While motionFlag is high, tiles in image column 0, column 159, row 0 or row 119 show palette index 1 in place of image data.
- R8: bufSel is sampled on the first clock of line 480. The sampled value is used for every fetch of the next frame. Changes to bufSel at other times have no effect until then.
- R9: While rstN is low: hSyncN=1, vSyncN=1, blankN=0, palIdx=0, memReq=0.
- R10: pixClk is the inverse of clk, so the DAC captures palIdx in the middle of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz pixel-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bufSel | input | 1 | On-screen buffer select (0 even, 1 odd addresses) |
| motionFlag | input | 1 | Motion indicator request |
| memReq | output | 1 | Fetch request to the memory arbiter |
| memAddr | output | 16 | Fetch address |
| memReady | input | 1 | One-cycle fetch completion pulse |
| memData | input | 8 | Fetched image pixel |
| palIdx | output | 8 | Palette index to the DAC |
| pixClk | output | 1 | Pixel clock to the DAC |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| blankN | output | 1 | Blank, active low |

## Verification
The assertions check the following on every cycle:
- the raster counters stay in range;
- blanked pixels carry index 0;
- no visible pixel uses a reserved index other than the indicator;
- the request is held with a stable, in-range address until ready, and is dropped right after.

Only the bench's scenarios can show the rest. These are the exact sync and blank positions, the 4x4 tile replication, and the fetch order and address, all checked against a reference raster. They also cover the clamping of low values and the border overlay while motion toggles. The last two are that a buffer-select change in mid-frame waits for the next vertical blank, and that stray ready pulses leave the picture untouched, with the arbiter answering at different latencies.

// File: rtl/qscan_pkg.sv
package qscan_pkg;
  typedef struct packed {
    logic visible;
    logic hsAct;
    logic vsAct;
    logic slotStart;
    logic issue;
    logic border;
    logic latchBuf;
  } strobe_t;
endpackage

// File: rtl/qscan_ctrl.sv
module qscan_ctrl
  import qscan_pkg::*;
#(
  parameter int IMG_W  = 160,
  parameter int IMG_H  = 120,
  parameter int SCALE  = 4,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int IW     = $clog2(IMG_W * IMG_H)
) (
  input  logic          clk,
  input  logic          rstN,
  output strobe_t       st,
  output logic [IW-1:0] fetchIdx
);
  localparam int H_VIS = IMG_W * SCALE;
  localparam int V_VIS = IMG_H * SCALE;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic          lineEnd;

  assign lineEnd = (hCnt == HW'(H_TOT - 1));

  // horizontal counter and the line counter it enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= (vCnt == VW'(V_TOT - 1)) ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    int h, v, nv, col, row, fRow, fCol;
    logic eolFetch, midFetch;
    h   = int'(hCnt);
    v   = int'(vCnt);
    nv  = (v == V_TOT - 1) ? 0 : v + 1;
    col = h / SCALE;
    row = v / SCALE;
    eolFetch = (h == H_TOT - SCALE) && (nv < V_VIS);
    midFetch = (v < V_VIS) && (h % SCALE == 0) && (h < H_VIS - SCALE);
    fRow = eolFetch ? nv / SCALE : row;
    fCol = eolFetch ? 0 : col + 1;
    st.visible   = (h < H_VIS) && (v < V_VIS);
    st.hsAct     = (h >= H_VIS + H_FP) && (h < H_VIS + H_FP + H_SYNC);
    st.vsAct     = (v >= V_VIS + V_FP) && (v < V_VIS + V_FP + V_SYNC);
    st.slotStart = st.visible && (h % SCALE == 0);
    st.issue     = eolFetch || midFetch;
    st.border    = (col == 0) || (col == IMG_W - 1) || (row == 0) || (row == IMG_H - 1);
    st.latchBuf  = (h == 0) && (v == V_VIS);
    fetchIdx     = IW'(fRow * IMG_W + fCol);
  end

  // R1: raster position never leaves the frame
  a_r1_frame_bounds: assert property (@(posedge clk) disable iff (!rstN)
    (hCnt < HW'(H_TOT)) && (vCnt < VW'(V_TOT)));
endmodule

// File: rtl/qscan_dp.sv
module qscan_dp
  import qscan_pkg::*;
#(
  parameter int         IW      = 15,
  parameter int         PIX_CNT = 19200,
  parameter logic [7:0] OVL_IDX = 8'd1,
  parameter logic [7:0] MIN_IDX = 8'd3
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     st,
  input  logic [IW-1:0] fetchIdx,
  input  logic        bufSel,
  input  logic        motionFlag,
  input  logic        memReady,
  input  logic [7:0]  memData,
  output logic        memReq,
  output logic [IW:0] memAddr,
  output logic [7:0]  palIdx,
  output logic        hSyncN,
  output logic        vSyncN,
  output logic        blankN
);
  logic [7:0] fetchBuf;
  logic [7:0] curPix;
  logic [7:0] pixNow;
  logic [7:0] shown;
  logic       frameBuf;
  logic       accept;

  assign accept = memReq && memReady;

  always_comb begin
    pixNow = st.slotStart ? fetchBuf : curPix;
    shown  = (pixNow < MIN_IDX) ? MIN_IDX : pixNow;
    if (motionFlag && st.border) shown = OVL_IDX;
  end

  // fetch handshake and buffer select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      memAddr  <= '0;
      fetchBuf <= '0;
      frameBuf <= 1'b0;
    end else begin
      if (st.issue) begin
        memReq  <= 1'b1;
        memAddr <= {fetchIdx, frameBuf};
      end else if (accept) begin
        memReq <= 1'b0;
      end
      if (accept) fetchBuf <= memData;
      if (st.latchBuf) frameBuf <= bufSel;
    end
  end

  // output register stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPix <= '0;
      palIdx <= '0;
      hSyncN <= 1'b1;
      vSyncN <= 1'b1;
      blankN <= 1'b0;
    end else begin
      if (st.slotStart) curPix <= fetchBuf;
      palIdx <= st.visible ? shown : 8'd0;
      hSyncN <= !st.hsAct;
      vSyncN <= !st.vsAct;
      blankN <= st.visible;
    end
  end

  a_r2_blank_zero: assert property (@(posedge clk) disable iff (!rstN)
    !blankN |-> palIdx == 8'd0);
  a_r6_no_reserved: assert property (@(posedge clk) disable iff (!rstN)
    blankN |-> (palIdx >= MIN_IDX || palIdx == OVL_IDX));
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq);
  a_r5_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && !st.issue |=> !memReq);
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(memAddr));
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr < (IW+1)'(2 * PIX_CNT));
endmodule

// File: rtl/qvga_fetch_scan.sv
module qvga_fetch_scan
  import qscan_pkg::*;
#(
  parameter int         IMG_W   = 160,
  parameter int         IMG_H   = 120,
  parameter int         SCALE   = 4,
  parameter int         H_FP    = 16,
  parameter int         H_SYNC  = 96,
  parameter int         H_BP    = 48,
  parameter int         V_FP    = 10,
  parameter int         V_SYNC  = 2,
  parameter int         V_BP    = 33,
  parameter logic [7:0] OVL_IDX = 8'd1,
  parameter int         IW      = $clog2(IMG_W * IMG_H),
  parameter int         AW      = IW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bufSel,
  input  logic          motionFlag,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic          memReady,
  input  logic [7:0]    memData,
  output logic [7:0]    palIdx,
  output logic          pixClk,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          blankN
);
  strobe_t       st;
  logic [IW-1:0] fetchIdx;

  assign pixClk = ~clk;

  qscan_ctrl #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .SCALE(SCALE),
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .IW(IW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .st(st), .fetchIdx(fetchIdx)
  );

  qscan_dp #(
    .IW(IW), .PIX_CNT(IMG_W * IMG_H), .OVL_IDX(OVL_IDX), .MIN_IDX(8'd3)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .fetchIdx(fetchIdx),
    .bufSel(bufSel), .motionFlag(motionFlag),
    .memReady(memReady), .memData(memData),
    .memReq(memReq), .memAddr(memAddr), .palIdx(palIdx),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .blankN(blankN)
  );
endmodule

// File: tb/qvga_fetch_scan_tb.sv
module qvga_fetch_scan_tb;
  localparam int W = 8, H = 6, SC = 4;
  localparam int HFP = 4, HS = 8, HBP = 4, VFP = 2, VS = 3, VBP = 2;
  localparam int HV = W * SC, VV = H * SC;
  localparam int HT = HV + HFP + HS + HBP, VT = VV + VFP + VS + VBP;
  localparam int FR = HT * VT;
  localparam int AW = $clog2(W * H) + 1;
  localparam int OVL = 1;

  logic clk = 0, rstN = 0, bufSel = 0, motionFlag = 0;
  logic memReady = 0;
  logic [7:0] memData = 0;
  logic memReq, pixClk, hSyncN, vSyncN, blankN;
  logic [AW-1:0] memAddr;
  logic [7:0] palIdx;

  always #4 clk = ~clk;

  qvga_fetch_scan #(
    .IMG_W(W), .IMG_H(H), .SCALE(SC), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .bufSel(bufSel), .motionFlag(motionFlag),
    .memReq(memReq), .memAddr(memAddr), .memReady(memReady), .memData(memData),
    .palIdx(palIdx), .pixClk(pixClk), .hSyncN(hSyncN), .vSyncN(vSyncN), .blankN(blankN)
  );

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pix(int a);
    if (a % 4 == 0) return (a / 4) % 3;
    return (a * 29 + 5) % 256;
  endfunction

  // reference raster model
  int h = 0, v = 0, mbuf = 0;
  int expPal = 0, expHs = 1, expVs = 1, expBl = 0;
  string palTag = "R9";
  bit armed = 0;
  int q[$];

  always @(posedge clk) begin
    if (!rstN) begin
      h = 0; v = 0; mbuf = 0;
      expPal = 0; expHs = 1; expVs = 1; expBl = 0; palTag = "R9";
      q.delete();
      armed = 1;
    end else begin
      int nv, r, c, raw;
      bit vis;
      vis   = (h < HV) && (v < VV);
      expBl = vis;
      expHs = !((h >= HV + HFP) && (h < HV + HFP + HS));
      expVs = !((v >= VV + VFP) && (v < VV + VFP + VS));
      expPal = 0;
      palTag = "R2";
      if (vis) begin
        r = v / SC; c = h / SC;
        raw = pix(2 * (r * W + c) + mbuf);
        expPal = (raw < 3) ? 3 : raw;
        palTag = (mbuf == 1) ? "R8" : "R3";
        if (raw < 3) palTag = "R6";
        if (motionFlag && (c == 0 || c == W - 1 || r == 0 || r == H - 1)) begin
          expPal = OVL; palTag = "R7";
        end
      end
      nv = (v == VT - 1) ? 0 : v + 1;
      if (h == HT - SC && nv < VV) q.push_back(2 * ((nv / SC) * W) + mbuf);
      else if (v < VV && h % SC == 0 && h < HV - SC)
        q.push_back(2 * ((v / SC) * W + h / SC + 1) + mbuf);
      if (h == 0 && v == VV) mbuf = int'(bufSel);
      if (h == HT - 1) begin h = 0; v = nv; end else h = h + 1;
    end
  end

  // compare on every clock, and act as the memory arbiter
  int cyc = 0, lat = 0, wcnt = 0, reqs = 0;
  bit seen = 0, ackPrev = 0, strayEn = 0;

  always @(negedge clk) begin
    bit ackNow;
    ackNow = 0;
    if (armed) begin
      chk(palIdx == 8'(expPal), palTag, "palIdx", palIdx, expPal);
      chk(hSyncN == expHs[0], rstN ? "R1" : "R9", "hSyncN", hSyncN, expHs);
      chk(vSyncN == expVs[0], rstN ? "R1" : "R9", "vSyncN", vSyncN, expVs);
      chk(blankN == expBl[0], rstN ? "R2" : "R9", "blankN", blankN, expBl);
    end
    if (!rstN) chk(memReq == 1'b0, "R9", "memReq in reset", memReq, 0);
    if (ackPrev) chk(memReq == 1'b0, "R5", "memReq after ready", memReq, 0);
    memReady = 0;
    if (rstN && memReq) begin
      if (!seen) begin
        seen = 1; wcnt = 0;
        if (q.size() == 0) chk(0, "R4", "unexpected fetch addr", memAddr, -1);
        else begin
          int e;
          e = q.pop_front();
          chk(int'(memAddr) == e, "R4", "memAddr", memAddr, e);
        end
      end
      if (wcnt == lat) begin
        memReady = 1; memData = 8'(pix(int'(memAddr)));
        seen = 0; reqs++; lat = reqs % 3; ackNow = 1;
      end else wcnt++;
    end else if (rstN && strayEn && (cyc % 5 == 0)) begin
      memReady = 1; memData = 8'hC7;  // R5: stray ready, must be ignored
    end
    ackPrev = ackNow;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(pixClk == 1'b1, "R10", "pixClk low phase", pixClk, 1);
    @(posedge clk); #1;
    chk(pixClk == 1'b0, "R10", "pixClk high phase", pixClk, 0);
    @(negedge clk);
    rstN = 1;
    for (int c = 0; c < 4 * FR + 300; c++) begin
      @(negedge clk);
      cyc = c;
      if (c == 400) bufSel = 1;        // R8: taken at next vertical blank
      if (c == FR + 300) bufSel = 0;   // R8: mid-frame change, deferred
      motionFlag = (c >= FR + 200 && c < FR + 900) || (c >= 2 * FR && c < 3 * FR);
      strayEn = (c >= 2 * FR);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule